// File: doc/BRIEF.md
# Video Line Capture Controller

This block takes the timing signals of a monochrome camera and writes one frame into an external frame memory. The inputs are a pixel clock, a horizontal sync, a frame sync and the parallel output of an external sample converter. All three camera timing inputs are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the block then detects its rising edge. During active video, every pixel clock edge starts a short sequence on the system clock. The memory address is already stable when the sequence starts. The converter gets a conversion strobe a set number of cycles later, and the returned sample is written a few cycles after that. The address advances only once the write is complete.

While horizontal sync is high, the converter chip select is low and pixel clock edges are ignored. On the leading edge of each sync pulse, the block writes a single line-boundary word of alternating ones and zeros, and that word takes up one address. The frame memory therefore holds each line as one marker followed by the line's samples. The memory depth is (pixels per line + 1) x lines. A capture is started by an arm pulse followed by a frame sync. It ends once the last address has been written, and the block then raises a done flag and ignores camera activity until it is armed again.

Top module: `vcap_ctrl`

## Requirements
- R1: After reset, mem_en_o, adc_cs_o, adc_conv_o, mem_we_o and done_o are low, and mem_addr_o is 0.
- R2: A frame sync rising edge starts a capture only after an arm_i pulse. Capture raises mem_en_o and adc_cs_o and sets mem_addr_o to 0. Before arming, frame sync and pixel clock edges cause no write and leave mem_en_o low.
- R3: For each accepted pixel clock rising edge, adc_conv_o pulses once, and mem_we_o pulses exactly WR_DLY-CONV_DLY system cycles later. mem_addr_o keeps the same value from the conversion strobe through the write.
- R4: A pixel write stores the sample_i value that the converter returns after the conversion strobe.
- R5: Consecutive writes go to consecutive addresses. The address changes only after a write or on a frame sync restart.
- R6: While horizontal sync is high, adc_cs_o is low and pixel clock edges produce no conversion and no write. adc_cs_o returns high after sync falls.
- R7: Each horizontal sync pulse writes exactly one marker word, however long the pulse is held. The marker has the MSB set and alternates from there down, so it is 6'b101010 at the default width. It occupies one address.
- R8: A frame sync rising edge during a capture restarts the address at 0.
- R9: The write to address MEM_DEPTH-1 ends the capture. done_o then goes high, mem_en_o and adc_cs_o go low, and mem_addr_o holds MEM_DEPTH. Later pixel clocks, syncs and frame syncs produce no write.
- R10: An arm_i pulse after done clears done_o, and the next frame sync starts a new capture at address 0.
- R11: mem_we_o is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Single-cycle pulse that arms the next capture |
| pix_clk_i | input | 1 | Camera pixel clock, asynchronous |
| hsync_i | input | 1 | Camera horizontal sync, high during retrace, asynchronous |
| fsync_i | input | 1 | Camera frame sync, asynchronous |
| sample_i | input | DW | Converter output |
| adc_cs_o | output | 1 | Converter chip select, active high |
| adc_conv_o | output | 1 | Converter start-of-conversion strobe |
| mem_addr_o | output | AW = clog2(MEM_DEPTH+1) | Frame memory address |
| mem_data_o | output | DW | Frame memory write data |
| mem_we_o | output | 1 | Frame memory write enable, one cycle per word |
| mem_en_o | output | 1 | Frame memory enable, high while capturing |
| done_o | output | 1 | Capture complete |

## Verification
The bench goes after pixel edges placed inside a sync pulse and syncs held across several pixel clocks. A design that gated the converter wrongly would store extra samples there, and one that detected the sync level instead of its edge would write repeated markers. The bench also checks the gap between the conversion strobe and the write, and the address seen at each of them; a mis-staged sequencer would write the previous sample or move the address too early. It restarts a frame in mid-capture, where a counter that is not cleared would continue from the old address. It also drives activity after the last address, where a missing stop would write past the end of memory or restart without a re-arm.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAP   = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/vcap_sync.sv
module vcap_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= async_i[i];
        sync_q <= meta_q;
      end
    end
    assign lvl_o[i] = sync_q;
  end
endmodule

// File: rtl/vcap_phase.sv
// Per-pixel sequencer: conversion strobe at CONV_DLY, write strobe at WR_DLY
// system cycles after start.
module vcap_phase #(
  parameter int CONV_DLY = 2,
  parameter int WR_DLY   = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic start_i,
  output logic busy_o,
  output logic conv_o,
  output logic wr_o
);
  localparam int CW = $clog2(WR_DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == CW'(WR_DLY)) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(1);
    end
  end

  assign busy_o = busy_q;
  assign conv_o = busy_q && (cnt_q == CW'(CONV_DLY));
  assign wr_o   = busy_q && (cnt_q == CW'(WR_DLY));
endmodule

// File: rtl/vcap_addr.sv
module vcap_addr #(
  parameter int AW    = 16,
  parameter int DEPTH = 60192
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == AW'(DEPTH - 1));
endmodule

// File: rtl/vcap_ctrl.sv
module vcap_ctrl
  import vcap_pkg::*;
#(
  parameter int LINE_PIX = 208,
  parameter int LINES    = 288,
  parameter int DW       = 6,
  parameter int CONV_DLY = 2,
  parameter int WR_DLY   = 5,
  localparam int MEM_DEPTH = (LINE_PIX + 1) * LINES,
  localparam int AW        = $clog2(MEM_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic          pix_clk_i,
  input  logic          hsync_i,
  input  logic          fsync_i,
  input  logic [DW-1:0] sample_i,
  output logic          adc_cs_o,
  output logic          adc_conv_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_we_o,
  output logic          mem_en_o,
  output logic          done_o
);
  // sample must be back from the converter before the write strobe
  initial begin
    if (CONV_DLY < 1 || WR_DLY < CONV_DLY + 2)
      $error("vcap_ctrl: need 1 <= CONV_DLY and CONV_DLY + 2 <= WR_DLY");
  end

  logic [DW-1:0] mark_w;
  for (genvar i = 0; i < DW; i++) begin : g_mark
    assign mark_w[i] = ((i % 2) == ((DW - 1) % 2));
  end

  logic [2:0] sync_lvl, prev_q, rise;
  vcap_sync #(.N(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({fsync_i, hsync_i, pix_clk_i}),
    .lvl_o  (sync_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_lvl;
  end
  assign rise = sync_lvl & ~prev_q;

  logic pix_rise, hs_rise, fs_rise, hs_lvl;
  assign pix_rise = rise[0];
  assign hs_rise  = rise[1];
  assign fs_rise  = rise[2];
  assign hs_lvl   = sync_lvl[1];

  cap_state_e state_q;
  logic capture, restart;
  logic busy, conv_stb, wr_stb, seq_start, seq_clr;
  logic [AW-1:0] addr;
  logic addr_last, addr_clr;
  logic mark_pend_q, mark_go;
  logic we_q, conv_q;
  logic [DW-1:0] data_q;

  assign capture  = (state_q == ST_CAP);
  assign restart  = fs_rise && (state_q == ST_ARMED || capture);
  assign addr_clr = restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: if (arm_i)   state_q <= ST_ARMED;
        ST_ARMED:         if (fs_rise) state_q <= ST_CAP;
        ST_CAP:           if (we_q && addr_last && !fs_rise) state_q <= ST_DONE;
        default:          state_q <= ST_IDLE;
      endcase
    end
  end

  assign seq_clr   = !capture || fs_rise;
  assign seq_start = pix_rise && capture && !hs_lvl && !busy && !fs_rise;

  vcap_phase #(.CONV_DLY(CONV_DLY), .WR_DLY(WR_DLY)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (seq_clr),
    .start_i(seq_start),
    .busy_o (busy),
    .conv_o (conv_stb),
    .wr_o   (wr_stb)
  );

  vcap_addr #(.AW(AW), .DEPTH(MEM_DEPTH)) u_addr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (addr_clr),
    .inc_i (we_q),
    .addr_o(addr),
    .last_o(addr_last)
  );

  // one marker per sync leading edge, deferred while a pixel is in flight
  assign mark_go = mark_pend_q && capture && !busy && !we_q && !fs_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   mark_pend_q <= 1'b0;
    else if (!capture || fs_rise)  mark_pend_q <= 1'b0;
    else if (hs_rise)              mark_pend_q <= 1'b1;
    else if (mark_go)              mark_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q   <= 1'b0;
      conv_q <= 1'b0;
      data_q <= '0;
    end else begin
      we_q   <= capture && !fs_rise && (wr_stb || mark_go);
      conv_q <= capture && !fs_rise && conv_stb;
      if (wr_stb)       data_q <= sample_i;
      else if (mark_go) data_q <= mark_w;
    end
  end

  assign adc_cs_o   = capture && !hs_lvl;
  assign adc_conv_o = conv_q;
  assign mem_addr_o = addr;
  assign mem_data_o = data_q;
  assign mem_we_o   = we_q;
  assign mem_en_o   = capture;
  assign done_o     = (state_q == ST_DONE);
endmodule

// File: rtl/vcap_ctrl_chk.sv
module vcap_ctrl_chk #(
  parameter int AW        = 16,
  parameter int MEM_DEPTH = 60192
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fs_rise_i,
  input logic          mem_we_o,
  input logic          mem_en_o,
  input logic          done_o,
  input logic          adc_cs_o,
  input logic          adc_conv_o,
  input logic [AW-1:0] mem_addr_o
);
  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R2
  we_in_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !fs_rise_i) |=> (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R5
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_o && !fs_rise_i) |=> $stable(mem_addr_o));

  // R9
  done_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_en_o && !adc_cs_o && mem_addr_o == AW'(MEM_DEPTH)));

  // R6
  cs_in_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_cs_o |-> mem_en_o);

  // R3
  conv_apart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_conv_o |-> !mem_we_o);
endmodule

bind vcap_ctrl vcap_ctrl_chk #(.AW(AW), .MEM_DEPTH(MEM_DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fs_rise_i (fs_rise),
  .mem_we_o  (mem_we_o),
  .mem_en_o  (mem_en_o),
  .done_o    (done_o),
  .adc_cs_o  (adc_cs_o),
  .adc_conv_o(adc_conv_o),
  .mem_addr_o(mem_addr_o)
);

// File: tb/vcap_ctrl_bench.sv
module vcap_ctrl_bench;
  localparam int CLK_P    = 10;
  localparam int LINE_PIX = 8;
  localparam int LINES    = 4;
  localparam int DW       = 6;
  localparam int CONV_DLY = 2;
  localparam int WR_DLY   = 5;
  localparam int DEPTH    = (LINE_PIX + 1) * LINES;
  localparam int AW       = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, pix = 1'b0, hs = 1'b0, fs = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [DW-1:0] nxt;
  logic adc_cs, adc_conv, mem_we, mem_en, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0, fails = 0, cyc = 0, wr_cnt = 0, exp_addr = 0, last_conv = 0;
  int conv_addr = 0;
  int exp_q[$];
  bit cap_exp = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  vcap_ctrl #(
    .LINE_PIX(LINE_PIX), .LINES(LINES), .DW(DW),
    .CONV_DLY(CONV_DLY), .WR_DLY(WR_DLY)
  ) u_vcap_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm),
    .pix_clk_i(pix), .hsync_i(hs), .fsync_i(fs), .sample_i(sample),
    .adc_cs_o(adc_cs), .adc_conv_o(adc_conv),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data),
    .mem_we_o(mem_we), .mem_en_o(mem_en), .done_o(done)
  );

  function automatic logic [DW-1:0] mark_word();
    logic [DW-1:0] w;
    for (int i = 0; i < DW; i++) w[i] = ((i % 2) == ((DW - 1) % 2));
    return w;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural converter: new sample after each conversion strobe
  always @(posedge clk) begin
    if (adc_conv) begin
      nxt = DW'($urandom);
      sample <= nxt;
      exp_q.push_back(int'(nxt));
    end
  end

  // write monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_conv) begin
        last_conv = cyc;
        conv_addr = int'(mem_addr);
      end
      if (mem_we) begin
        int e;
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected write", int'(mem_addr), -1);
        end else begin
          e = exp_q.pop_front();
          chk(int'(mem_addr) == exp_addr, "R5 write address", int'(mem_addr), exp_addr);
          if (e >= 256) begin
            chk(mem_data == DW'(e), "R7 marker word", int'(mem_data), e - 256);
          end else begin
            chk(int'(mem_data) == e, "R4 sample data", int'(mem_data), e);
            chk(cyc - last_conv == WR_DLY - CONV_DLY, "R3 conv-to-write gap",
                cyc - last_conv, WR_DLY - CONV_DLY);
            chk(int'(mem_addr) == conv_addr, "R3 address stable", int'(mem_addr), conv_addr);
          end
          exp_addr++;
        end
      end
    end
  end

  task automatic pix_pulse(input int hi, input int lo);
    pix = 1'b1; tick(hi);
    pix = 1'b0; tick(lo);
  endtask

  task automatic rnd_pix();
    pix_pulse(4 + int'($urandom % 3), 4 + int'($urandom % 3));
  endtask

  // sync pulse with n pixel edges buried inside it
  task automatic hs_pulse(input int n);
    if (cap_exp) exp_q.push_back(256 + int'(mark_word()));
    hs = 1'b1; tick(2);
    for (int k = 0; k < n; k++) begin
      pix_pulse(3, 3);
      if (k == 0 && cap_exp) begin
        at_neg();
        chk(adc_cs == 1'b0, "R6 cs low in sync", int'(adc_cs), 0);
        tick(0);
      end
    end
    tick(2);
    hs = 1'b0; tick(6);
    if (cap_exp) begin
      at_neg();
      chk(adc_cs == 1'b1, "R6 cs back after sync", int'(adc_cs), 1);
      tick(1);
    end
  endtask

  task automatic fs_pulse();
    fs = 1'b1; tick(4);
    fs = 1'b0; tick(4);
  endtask

  task automatic line(input int nh);
    hs_pulse(nh);
    for (int p = 0; p < LINE_PIX; p++) rnd_pix();
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(5);
    at_neg();
    // R1 reset state
    chk(!done && !mem_we && !mem_en && !adc_cs && !adc_conv && mem_addr == '0,
        "R1 reset outputs", int'({done, mem_we, mem_en, adc_cs, adc_conv}), 0);
    rst_n = 1'b1;
    tick(3);

    // R2 not armed: frame sync and pixels ignored
    fs_pulse();
    hs_pulse(1);
    repeat (3) rnd_pix();
    tick(10);
    at_neg();
    chk(wr_cnt == 0, "R2 no write before arm", wr_cnt, 0);
    chk(mem_en == 1'b0, "R2 mem_en low before arm", int'(mem_en), 0);

    // R2 arm then frame sync
    tick(0);
    arm = 1'b1; tick(1); arm = 1'b0;
    fs_pulse();
    cap_exp = 1'b1; exp_addr = 0;
    at_neg();
    chk(mem_en && adc_cs && mem_addr == '0, "R2 capture started",
        int'({mem_en, adc_cs}) * 256 + int'(mem_addr), 3 * 256);
    tick(1);

    // R8 mid-frame restart
    hs_pulse(1);
    repeat (3) rnd_pix();
    tick(12);
    at_neg();
    chk(int'(mem_addr) == 4, "R5 address after partial line", int'(mem_addr), 4);
    tick(0);
    fs_pulse();
    exp_addr = 0;
    at_neg();
    chk(mem_addr == '0, "R8 restart address", int'(mem_addr), 0);
    tick(1);

    // full frame; R7 long syncs with several buried pixel edges
    for (int l = 0; l < LINES; l++) line(1 + int'($urandom % 3));
    tick(12);
    at_neg();
    chk(done == 1'b1, "R9 done raised", int'(done), 1);
    chk(int'(mem_addr) == DEPTH, "R9 address at depth", int'(mem_addr), DEPTH);
    chk(!mem_en && !adc_cs, "R9 memory and converter off", int'({mem_en, adc_cs}), 0);
    chk(exp_q.size() == 0, "R7 all expected words written", exp_q.size(), 0);
    tick(1);

    // R9 activity after done is ignored, R10 frame sync without arm too
    cap_exp = 1'b0;
    begin
      int w0;
      w0 = wr_cnt;
      hs_pulse(2);
      repeat (4) rnd_pix();
      fs_pulse();
      repeat (2) rnd_pix();
      tick(10);
      at_neg();
      chk(wr_cnt == w0, "R9 no write after done", wr_cnt, w0);
      chk(done == 1'b1, "R10 done holds without arm", int'(done), 1);
      tick(0);
    end

    // R10 re-arm and capture again from address 0
    arm = 1'b1; tick(1); arm = 1'b0;
    at_neg();
    chk(done == 1'b0, "R10 done cleared by arm", int'(done), 0);
    tick(0);
    fs_pulse();
    cap_exp = 1'b1; exp_addr = 0;
    at_neg();
    chk(mem_en && mem_addr == '0, "R10 new capture at 0", int'(mem_addr), 0);
    tick(1);
    hs_pulse(1);
    repeat (2) rnd_pix();
    tick(12);
    at_neg();
    chk(int'(mem_addr) == 3, "R10 second capture address", int'(mem_addr), 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule